// File: doc/BRIEF.md
# Slot Hotplug Controller

This block keeps the hotplug bookkeeping for up to 32 slots on one expansion bus. Slot event inputs report that a card has been inserted or removed, together with a flag that marks insertions made while the system is first being built. Each hot event is stored as a single bit in an "arrived" mask or a "departed" mask. It also raises bit 1 of an event status byte, which a general-purpose event block can turn into an interrupt.

Host software reads the two masks through a four-word register window. It finds out which slots may be removed while running by reading the removable word. It asks for a slot to be taken out by writing a bit vector to the eject word. The block answers that write with a one-cycle request that carries the slot number, and only when the lowest set bit names a slot that supports hotplug. Bus enumeration and device teardown happen elsewhere.

Top module: `slot_hp_ctrl`

## Requirements
- R1: After reset both masks read zero, the event status byte is zero and no eject request is asserted.
- R2: An insertion event with the coldplug flag set changes neither mask and does not touch the status byte.
- R3: Every other event first clears both masks. It then sets bit `slot` in the arrived mask for an insertion, or in the departed mask for a removal, so exactly one bit is set across the two masks.
- R4: Every hot event sets bit 1 of the status byte (value 8'h02). The bit stays set, and all other status bits stay zero.
- R5: The word index selects the register: 0 is the arrived mask, 1 the departed mask, 2 the eject word, 3 the removable word. Read data appears on the clock edge that samples the read strobe.
- R6: The eject word always reads zero. A write to it produces, one cycle later, a single-cycle eject request carrying the 5-bit index of the lowest set bit of the written value.
- R7: If the slot named by that lowest set bit is not hotplug-capable, no request is issued, even if higher bits name capable slots.
- R8: Writing zero to the eject word produces no request.
- R9: The removable word reads as the hotplug-capable mask, with 1 meaning capable. Writes to the arrived, departed and removable words are ignored.
- R10: The coldplug flag suppresses insertions only. A removal with the flag set is handled as an ordinary removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 2 | Word index in the window (byte offset divided by 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ev_valid | input | 1 | Slot event strobe |
| ev_slot | input | 5 | Slot index of the event |
| ev_insert | input | 1 | 1 = insertion, 0 = removal |
| ev_cold | input | 1 | Event belongs to initial system build |
| hp_capable | input | 32 | Per-slot hotplug-capable mask |
| evt_sts | output | 8 | Event status byte, bit 1 = slot hotplug |
| ej_valid | output | 1 | Eject request pulse |
| ej_slot | output | 5 | Slot to eject, valid with ej_valid |

## Verification
An event strobed on one edge updates the masks and the status byte on that same edge. A read issued afterwards returns the new mask on the edge that samples it, so the bench reads it at the following falling edge. An eject write captured on an edge raises the request on that same edge, and the request drops on the next. The bench therefore samples it at the falling edge straight after the write and again one cycle later, to prove it lasts only one cycle. All stimulus changes at falling edges and all sampling happens there, so no result depends on process order at a rising edge.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

  // Word indices of the host register window; software decodes these.
  typedef enum logic [1:0] {
    WIN_UP    = 2'd0,
    WIN_DOWN  = 2'd1,
    WIN_EJECT = 2'd2,
    WIN_RMV   = 2'd3
  } win_word_e;

  // Position of the slot-hotplug flag inside the event status byte.
  localparam int STS_HP_BIT = 1;

endpackage

// File: rtl/hp_event_track.sv
module hp_event_track
  import slot_hp_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int SLW   = $clog2(NSLOT),
  parameter int STSW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [SLW-1:0]   ev_slot,
  input  logic             ev_insert,
  input  logic             ev_cold,
  output logic [NSLOT-1:0] up_mask,
  output logic [NSLOT-1:0] down_mask,
  output logic [STSW-1:0]  evt_sts,
  output logic             hot_evt
);

  localparam logic [NSLOT-1:0] ONE = {{(NSLOT-1){1'b0}}, 1'b1};

  function automatic logic [NSLOT-1:0] slot_bit(input logic [SLW-1:0] s);
    return ONE << s;
  endfunction

  logic cold_drop;
  logic [NSLOT-1:0] ev_bit;

  assign cold_drop = ev_valid && ev_cold && ev_insert;
  assign hot_evt   = ev_valid && !cold_drop;
  assign ev_bit    = slot_bit(ev_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_mask   <= '0;
      down_mask <= '0;
      evt_sts   <= '0;
    end else if (hot_evt) begin
      up_mask   <= ev_insert ? ev_bit : '0;
      down_mask <= ev_insert ? '0 : ev_bit;
      evt_sts[STS_HP_BIT] <= 1'b1;
    end
  end

  // R2: a coldplug insertion leaves both masks untouched
  a_r2_cold_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    cold_drop |=> ($stable(up_mask) && $stable(down_mask)));

  // R3: after a hot event exactly one bit is set across the two masks
  a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    hot_evt |=> ($countones({up_mask, down_mask}) == 1));

  // R4: a hot event leaves the hotplug status flag set
  a_r4_sts_set: assert property (@(posedge clk) disable iff (!rst_n)
    hot_evt |=> evt_sts[STS_HP_BIT]);

  // R4: the hotplug status flag never falls while out of reset
  a_r4_sts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sts[STS_HP_BIT] |=> evt_sts[STS_HP_BIT]);

endmodule

// File: rtl/hp_eject_unit.sv
module hp_eject_unit #(
  parameter int NSLOT = 32,
  parameter int SLW   = $clog2(NSLOT),
  parameter int DW    = 32,
  parameter int IDXW  = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_eject,
  input  logic [DW-1:0]    wdata,
  input  logic [NSLOT-1:0] hp_capable,
  output logic             ej_valid,
  output logic [SLW-1:0]   ej_slot
);

  // Returns {found, index} of the lowest set bit.
  function automatic logic [IDXW:0] lowest_set(input logic [DW-1:0] v);
    logic [IDXW:0] r;
    r = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDXW'(i)};
    end
    return r;
  endfunction

  logic [IDXW:0]   enc;
  logic            found;
  logic [IDXW-1:0] idx;
  logic            in_range;
  logic            capable;
  logic            fire;

  assign enc      = lowest_set(wdata);
  assign found    = enc[IDXW];
  assign idx      = enc[IDXW-1:0];
  assign in_range = (32'(idx) < NSLOT);
  assign capable  = in_range && hp_capable[SLW'(idx)];
  assign fire     = wr_eject && found && capable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ej_valid <= 1'b0;
      ej_slot  <= '0;
    end else begin
      ej_valid <= fire;
      if (fire) ej_slot <= SLW'(idx);
    end
  end

  // R8: writing zero never yields a request
  a_r8_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eject && (wdata == '0)) |=> !ej_valid);

  // R6: a request follows a write whose lowest set bit is the reported slot
  a_r6_lowest_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> ($past(wr_eject)
                  && ((($past(wdata) >> ej_slot) & DW'(1)) == DW'(1))
                  && (($past(wdata) & ((DW'(1) << ej_slot) - DW'(1))) == '0)));

  // R7: the reported slot was hotplug-capable when the write arrived
  a_r7_capable_only: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> ((($past(hp_capable) >> ej_slot) & NSLOT'(1)) == NSLOT'(1)));

endmodule

// File: rtl/hp_reg_read.sv
module hp_reg_read
  import slot_hp_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [1:0]       rd_word,
  input  logic [NSLOT-1:0] up_mask,
  input  logic [NSLOT-1:0] down_mask,
  input  logic [NSLOT-1:0] hp_capable,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] rmv_word;
  logic [DW-1:0] nxt;

  generate
    if (DW > NSLOT) begin : g_pad
      assign rmv_word = {{(DW-NSLOT){1'b1}}, hp_capable};
    end else begin : g_full
      assign rmv_word = DW'(hp_capable);
    end
  endgenerate

  always_comb begin
    unique case (win_word_e'(rd_word))
      WIN_UP:    nxt = DW'(up_mask);
      WIN_DOWN:  nxt = DW'(down_mask);
      WIN_EJECT: nxt = '0;
      WIN_RMV:   nxt = rmv_word;
      default:   nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= nxt;
  end

  // R6: the eject word reads as zero
  a_r6_eject_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_word == 2'(WIN_EJECT))) |=> (rdata == '0));

  // R9: removable reads carry the capable mask from the sampling edge
  a_r9_rmv_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_word == 2'(WIN_RMV))) |=> (rdata[NSLOT-1:0] == $past(hp_capable)));

endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
  import slot_hp_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int SLW   = $clog2(NSLOT),
  parameter int DW    = 32,
  parameter int STSW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [1:0]       reg_word,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             ev_valid,
  input  logic [SLW-1:0]   ev_slot,
  input  logic             ev_insert,
  input  logic             ev_cold,
  input  logic [NSLOT-1:0] hp_capable,
  output logic [STSW-1:0]  evt_sts,
  output logic             ej_valid,
  output logic [SLW-1:0]   ej_slot
);

  logic [NSLOT-1:0] up_mask;
  logic [NSLOT-1:0] down_mask;
  logic             hot_evt;
  logic             wr_eject;
  logic             wr_mask;

  assign wr_eject = reg_wr && (reg_word == 2'(WIN_EJECT));
  assign wr_mask  = reg_wr && ((reg_word == 2'(WIN_UP)) || (reg_word == 2'(WIN_DOWN)));

  hp_event_track #(.NSLOT(NSLOT), .SLW(SLW), .STSW(STSW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_slot   (ev_slot),
    .ev_insert (ev_insert),
    .ev_cold   (ev_cold),
    .up_mask   (up_mask),
    .down_mask (down_mask),
    .evt_sts   (evt_sts),
    .hot_evt   (hot_evt)
  );

  hp_eject_unit #(.NSLOT(NSLOT), .SLW(SLW), .DW(DW)) u_eject (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_eject   (wr_eject),
    .wdata      (reg_wdata),
    .hp_capable (hp_capable),
    .ej_valid   (ej_valid),
    .ej_slot    (ej_slot)
  );

  hp_reg_read #(.NSLOT(NSLOT), .DW(DW)) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (reg_rd),
    .rd_word    (reg_word),
    .up_mask    (up_mask),
    .down_mask  (down_mask),
    .hp_capable (hp_capable),
    .rdata      (reg_rdata)
  );

  // R9: host writes to the mask words leave the masks as they were
  a_r9_mask_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !ev_valid) |=> ($stable(up_mask) && $stable(down_mask)));

  // R1: no eject request while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> !ej_valid);

endmodule

// File: tb/slot_hp_ctrl_tb.sv
module slot_hp_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_word = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_valid = 1'b0;
  logic [4:0]  ev_slot = '0;
  logic        ev_insert = 1'b0;
  logic        ev_cold = 1'b0;
  logic [31:0] hp_capable = 32'hFFFF_FFEF;
  logic [7:0]  evt_sts;
  logic        ej_valid;
  logic [4:0]  ej_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  slot_hp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_valid(ev_valid), .ev_slot(ev_slot), .ev_insert(ev_insert),
    .ev_cold(ev_cold), .hp_capable(hp_capable), .evt_sts(evt_sts),
    .ej_valid(ej_valid), .ej_slot(ej_slot)
  );

  typedef struct packed {
    logic [4:0]  slot;
    logic        ins;
    logic        cold;
    logic [31:0] up;
    logic [31:0] dn;
  } vec_t;

  // Event vectors with expected masks afterwards (R3; entry 2 is R2, entry 3 is R10)
  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{5'd5,  1'b1, 1'b0, 32'h0000_0020, 32'h0000_0000},
    '{5'd31, 1'b0, 1'b0, 32'h0000_0000, 32'h8000_0000},
    '{5'd0,  1'b1, 1'b1, 32'h0000_0000, 32'h8000_0000},
    '{5'd7,  1'b0, 1'b1, 32'h0000_0000, 32'h0000_0080},
    '{5'd12, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_0000},
    '{5'd12, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_1000},
    '{5'd0,  1'b1, 1'b0, 32'h0000_0001, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_word = w;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_write(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_word = w; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_event(input logic [4:0] s, input logic ins, input logic cold);
    @(negedge clk);
    ev_valid = 1'b1; ev_slot = s; ev_insert = ins; ev_cold = cold;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_eject(input logic [31:0] d, output logic v1,
                          output logic [4:0] s, output logic v2);
    @(negedge clk);
    reg_wr = 1'b1; reg_word = 2'd2; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    v1 = ej_valid; s = ej_slot;
    @(negedge clk);
    v2 = ej_valid;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic v1, v2;
    logic [4:0] s;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 ej_valid", 32'(ej_valid), 32'd0);
    chk("R1 evt_sts", 32'(evt_sts), 32'd0);
    do_read(2'd0, d); chk("R1 up", d, 32'd0);
    do_read(2'd1, d); chk("R1 down", d, 32'd0);

    // R2: coldplug insert from reset changes nothing, status stays clear
    do_event(5'd3, 1'b1, 1'b1);
    do_read(2'd0, d); chk("R2 up", d, 32'd0);
    do_read(2'd1, d); chk("R2 down", d, 32'd0);
    chk("R2 evt_sts", 32'(evt_sts), 32'd0);

    // R3, R2, R10: vector table
    for (int i = 0; i < NV; i++) begin
      do_event(VEC[i].slot, VEC[i].ins, VEC[i].cold);
      do_read(2'd0, d);
      chk($sformatf("R3 vec%0d up", i), d, VEC[i].up);
      do_read(2'd1, d);
      chk($sformatf("R3 vec%0d down", i), d, VEC[i].dn);
    end

    // R4: status byte is exactly 8'h02 and stays so
    chk("R4 evt_sts", 32'(evt_sts), 32'h02);

    // R9: writes to mask and removable words are ignored
    do_write(2'd0, 32'hFFFF_FFFF);
    do_write(2'd1, 32'hFFFF_FFFF);
    do_write(2'd3, 32'h0000_0000);
    do_read(2'd0, d); chk("R9 up after write", d, 32'h0000_0001);
    do_read(2'd1, d); chk("R9 down after write", d, 32'h0000_0000);
    do_read(2'd3, d); chk("R9 removable", d, 32'hFFFF_FFEF);
    hp_capable = 32'h7FFF_FFFF;
    do_read(2'd3, d); chk("R9 removable tracks input", d, 32'h7FFF_FFFF);
    hp_capable = 32'hFFFF_FFEF;

    // R5/R6: eject word reads zero
    do_read(2'd2, d); chk("R6 eject read", d, 32'd0);

    // R6: lowest of bits 9 and 11
    do_eject(32'h0000_0A00, v1, s, v2);
    chk("R6 pulse", 32'(v1), 32'd1);
    chk("R6 slot", 32'(s), 32'd9);
    chk("R6 single cycle", 32'(v2), 32'd0);

    // R6: top slot
    do_eject(32'h8000_0000, v1, s, v2);
    chk("R6 pulse31", 32'(v1), 32'd1);
    chk("R6 slot31", 32'(s), 32'd31);
    chk("R6 single31", 32'(v2), 32'd0);

    // R7: lowest bit 4 names a non-capable slot, bit 5 capable
    do_eject(32'h0000_0030, v1, s, v2);
    chk("R7 no pulse", 32'(v1), 32'd0);
    chk("R7 no late pulse", 32'(v2), 32'd0);

    // R8: zero write
    do_eject(32'h0000_0000, v1, s, v2);
    chk("R8 no pulse", 32'(v1), 32'd0);
    chk("R8 no late pulse", 32'(v2), 32'd0);

    // R4: status still set after all traffic
    chk("R4 sticky", 32'(evt_sts), 32'h02);

    finish_run();
  end

endmodule